// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block is the status register of a clocked serial transfer unit. It holds five sticky flags: transmit buffer empty, transmit finished, receive buffer full, receive overrun and chip-select conflict. The shift engine, the data buffers and the pin logic sit outside the block. They report what happens through single-cycle event strobes and a few level inputs, and the block turns these into flag updates. Software reads the register as one byte. Bits that carry no flag always read as zero.

Software cannot set a flag. It clears a flag with a two-step handshake: it first reads the register while that flag is 1, then writes 0 to that bit. Each flag keeps a private marker for this. A register read arms the marker of every flag that reads as 1. A 0 write clears only flags whose markers are armed. Any register write disarms all markers. Some accesses to the data buffers clear flags as a side effect: a transmit buffer write clears the empty and finished flags, and a receive buffer read clears the full flag.

A pending overrun raises a transfer inhibit output, which the transfer unit uses to hold off both directions. The inhibit drops once software clears the overrun flag. The conflict flag watches the chip-select input in four-wire mode, with a different rule for master and for slave.

Top module: `ser_status_reg`

## Requirements
- R1: After reset the register reads 00h and the transfer inhibit output is 0.
- R2: Writing 1 to a flag bit never sets it. Writing 0 clears a flag only if a register read has returned that flag as 1 since the last register write. Any register write uses up all armed reads.
- R3: Bits 4, 3 and 1 always read 0, and writes to them have no effect.
- R4: A receive-complete strobe sets the receive-full flag (bit 5). A receive buffer read strobe clears it.
- R5: A receive-complete strobe while receive-full is 1, without a receive buffer read in the same cycle, sets the overrun flag (bit 2). The transfer inhibit output is 1 exactly while overrun is 1.
- R6: The transmit-empty flag (bit 7) is set by a buffer-to-shifter load strobe, and by the transmit enable input going from 0 to 1.
- R7: A transmit buffer write strobe clears both transmit-empty and transmit-end.
- R8: A last-bit strobe sets the transmit-end flag (bit 6) only while transmit-empty is 1. While transmit-empty is 0 it leaves transmit-end unchanged.
- R9: In four-wire master mode, a transfer start strobe while chip select is low sets the conflict flag (bit 0). Outside four-wire mode it does not.
- R10: In four-wire slave mode, a low-to-high change of chip select while a transfer is busy sets the conflict flag. With no transfer busy it does not.
- R11: When a hardware set and any clear, from hardware or software, reach a flag in the same cycle, the flag ends up set.
- R12: Every flag update takes effect at the first rising clock edge after its strobe. Read data is combinational from the current flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_rd_i | input | 1 | Software read strobe for this register |
| reg_wr_i | input | 1 | Software write strobe for this register |
| reg_wdata_i | input | REG_W | Software write data |
| reg_rdata_o | output | REG_W | Current register value |
| txbuf_wr_i | input | 1 | Transmit data buffer written |
| rxbuf_rd_i | input | 1 | Receive data buffer read |
| shift_load_i | input | 1 | Transmit buffer moved into the shifter |
| last_bit_i | input | 1 | Last bit of a transmitted frame shifted out |
| rx_done_i | input | 1 | A reception completed |
| tx_en_i | input | 1 | Transmit enable level |
| four_wire_i | input | 1 | Four-wire mode selected |
| master_i | input | 1 | Unit acts as master |
| cs_n_i | input | 1 | Synchronised chip-select input, active low |
| xfer_start_i | input | 1 | A transfer begins |
| xfer_busy_i | input | 1 | A transfer is in progress |
| xfer_inhibit_o | output | 1 | Transmit and receive forced off while overrun is pending |

## Verification
Every strobe or level change lands in a flag register at the first rising edge after it is applied. Read data and the inhibit output follow the flags with no further delay, so each result is due exactly one edge after its stimulus. The bench applies stimulus at a falling edge and drops it at the next falling edge, by which time one rising edge has passed. It then samples the read data before any further edge. Chip-select edge cases take two such steps, because the pin's previous level is registered first. Reads used for checking also arm the clear markers, and the bench plans the handshake sequences around that.

// File: rtl/ss_stat_pkg.sv
package ss_stat_pkg;
   // flag slots inside the block (not bit positions in the register)
   localparam int unsigned FL_TXE  = 0;
   localparam int unsigned FL_TEND = 1;
   localparam int unsigned FL_RXF  = 2;
   localparam int unsigned FL_OVR  = 3;
   localparam int unsigned FL_CFL  = 4;
   localparam int unsigned NFLAG   = 5;
endpackage

// File: rtl/ss_flag_cell.sv
module ss_flag_cell #(
   parameter bit SW_CLR_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic hwclr_i,
   input  logic rd_i,
   input  logic wr_i,
   input  logic wr_bit_i,
   output logic flag_o
);
   logic flag_q;
   logic mark_q;
   logic sw_clr;

   generate
      if (SW_CLR_EN) begin : g_sw
         // marker: armed by a read that sees 1, dropped by any write or hw clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                mark_q <= 1'b0;
            else if (wr_i || hwclr_i)  mark_q <= 1'b0;
            else if (rd_i && flag_q)   mark_q <= 1'b1;
         end
         assign sw_clr = wr_i && !wr_bit_i && mark_q;
      end else begin : g_nosw
         logic unused_sw;
         assign unused_sw = ^{rd_i, wr_i, wr_bit_i};
         assign mark_q    = 1'b0;
         assign sw_clr    = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  flag_q <= 1'b0;
      else if (set_i)              flag_q <= 1'b1;
      else if (hwclr_i || sw_clr)  flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);  // R11
   AST_WR1_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !flag_o && !set_i) |=> !flag_o);  // R2
   AST_CLR_NEEDS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && flag_o && !mark_q && !set_i && !hwclr_i) |=> flag_o);  // R2
endmodule

// File: rtl/ss_edge_det.sv
module ss_edge_det #(
   parameter bit RISE    = 1'b1,
   parameter bit RST_LVL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic edge_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_LVL;
      else        prev_q <= lvl_i;
   end

   generate
      if (RISE) begin : g_rise
         assign edge_o = lvl_i & ~prev_q;
      end else begin : g_fall
         assign edge_o = ~lvl_i & prev_q;
      end
   endgenerate
endmodule

// File: rtl/ss_conflict_det.sv
module ss_conflict_det #(
   parameter bit SLAVE_CHK_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic four_wire_i,
   input  logic master_i,
   input  logic cs_n_i,
   input  logic start_i,
   input  logic busy_i,
   output logic hit_o
);
   logic master_hit;
   logic slave_hit;

   assign master_hit = four_wire_i & master_i & start_i & ~cs_n_i;

   generate
      if (SLAVE_CHK_EN) begin : g_slave
         logic cs_rise;
         ss_edge_det #(.RISE(1'b1), .RST_LVL(1'b1)) u_cs_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (cs_n_i),
            .edge_o (cs_rise)
         );
         assign slave_hit = four_wire_i & ~master_i & busy_i & cs_rise;
      end else begin : g_noslave
         logic unused_slave;
         assign unused_slave = ^{busy_i, clk, rst_n};
         assign slave_hit    = 1'b0;
      end
   endgenerate

   assign hit_o = master_hit | slave_hit;
endmodule

// File: rtl/ser_status_reg.sv
module ser_status_reg
   import ss_stat_pkg::*;
#(
   parameter int unsigned REG_W        = 8,
   parameter int unsigned P_TXE        = 7,
   parameter int unsigned P_TEND       = 6,
   parameter int unsigned P_RXF        = 5,
   parameter int unsigned P_OVR        = 2,
   parameter int unsigned P_CFL        = 0,
   parameter bit          CONFLICT_EN  = 1'b1,
   parameter bit          SLAVE_CHK_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_rd_i,
   input  logic             reg_wr_i,
   input  logic [REG_W-1:0] reg_wdata_i,
   output logic [REG_W-1:0] reg_rdata_o,
   input  logic             txbuf_wr_i,
   input  logic             rxbuf_rd_i,
   input  logic             shift_load_i,
   input  logic             last_bit_i,
   input  logic             rx_done_i,
   input  logic             tx_en_i,
   input  logic             four_wire_i,
   input  logic             master_i,
   input  logic             cs_n_i,
   input  logic             xfer_start_i,
   input  logic             xfer_busy_i,
   output logic             xfer_inhibit_o
);
   localparam int unsigned POS [NFLAG] = '{P_TXE, P_TEND, P_RXF, P_OVR, P_CFL};

   initial begin : elab_chk
      assert (REG_W >= NFLAG) else $error("register narrower than flag count");
      for (int i = 0; i < int'(NFLAG); i++) begin
         assert (POS[i] < REG_W) else $error("flag position outside register");
         for (int j = i + 1; j < int'(NFLAG); j++)
            assert (POS[i] != POS[j]) else $error("two flags share a bit");
      end
   end

   logic [NFLAG-1:0] flg;
   logic [NFLAG-1:0] set_v;
   logic [NFLAG-1:0] clr_v;
   logic             tx_rise;
   logic             cfl_hit;

   ss_edge_det #(.RISE(1'b1), .RST_LVL(1'b0)) u_txen_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (tx_en_i),
      .edge_o (tx_rise)
   );

   generate
      if (CONFLICT_EN) begin : g_cfl
         ss_conflict_det #(.SLAVE_CHK_EN(SLAVE_CHK_EN)) u_cfl (
            .clk         (clk),
            .rst_n       (rst_n),
            .four_wire_i (four_wire_i),
            .master_i    (master_i),
            .cs_n_i      (cs_n_i),
            .start_i     (xfer_start_i),
            .busy_i      (xfer_busy_i),
            .hit_o       (cfl_hit)
         );
      end else begin : g_nocfl
         logic unused_cfl;
         assign unused_cfl = ^{four_wire_i, master_i, cs_n_i, xfer_start_i, xfer_busy_i};
         assign cfl_hit    = 1'b0;
      end
   endgenerate

   always_comb begin
      set_v          = '0;
      clr_v          = '0;
      set_v[FL_TXE]  = shift_load_i | tx_rise;
      clr_v[FL_TXE]  = txbuf_wr_i;
      set_v[FL_TEND] = last_bit_i & flg[FL_TXE];
      clr_v[FL_TEND] = txbuf_wr_i;
      set_v[FL_RXF]  = rx_done_i;
      clr_v[FL_RXF]  = rxbuf_rd_i;
      set_v[FL_OVR]  = rx_done_i & flg[FL_RXF] & ~rxbuf_rd_i;
      set_v[FL_CFL]  = cfl_hit;
   end

   for (genvar g = 0; g < int'(NFLAG); g++) begin : g_flag
      ss_flag_cell #(.SW_CLR_EN(1'b1)) u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .set_i    (set_v[g]),
         .hwclr_i  (clr_v[g]),
         .rd_i     (reg_rd_i),
         .wr_i     (reg_wr_i),
         .wr_bit_i (reg_wdata_i[POS[g]]),
         .flag_o   (flg[g])
      );
   end

   always_comb begin
      reg_rdata_o = '0;
      for (int k = 0; k < int'(NFLAG); k++)
         reg_rdata_o[POS[k]] = flg[k];
   end

   assign xfer_inhibit_o = flg[FL_OVR];

   AST_RXF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done_i |=> reg_rdata_o[P_RXF]);  // R4
   AST_RXF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (rxbuf_rd_i && !rx_done_i) |=> !reg_rdata_o[P_RXF]);  // R4
   AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done_i && reg_rdata_o[P_RXF] && !rxbuf_rd_i) |=> xfer_inhibit_o);  // R5
   AST_TXE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      shift_load_i |=> reg_rdata_o[P_TXE]);  // R6
   AST_TXBUF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (txbuf_wr_i && !shift_load_i && !last_bit_i && $past(rst_n) && $stable(tx_en_i))
      |=> (!reg_rdata_o[P_TXE] && !reg_rdata_o[P_TEND]));  // R7
   AST_TEND_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_rdata_o[P_TEND]) |-> $past(reg_rdata_o[P_TXE]));  // R8

   if (CONFLICT_EN) begin : g_cfl_ast
      AST_CFL_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
         (xfer_start_i && four_wire_i && master_i && !cs_n_i) |=> reg_rdata_o[P_CFL]);  // R9
      if (SLAVE_CHK_EN) begin : g_slave_ast
         AST_CFL_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
            (four_wire_i && !master_i && xfer_busy_i && $past(rst_n) && cs_n_i && !$past(cs_n_i))
            |=> reg_rdata_o[P_CFL]);  // R10
      end
   end
endmodule

// File: tb/tb_ser_status_reg.sv
`timescale 1ns/1ps
module tb_ser_status_reg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_rd = 0, reg_wr = 0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       txbuf_wr = 0, rxbuf_rd = 0, shift_load = 0, last_bit = 0, rx_done = 0;
   logic       tx_en = 0, four_wire = 0, master = 0, cs_n = 1, xstart = 0, xbusy = 0;
   logic       inhibit;
   int         n_chk = 0, n_fail = 0;
   bit         done = 0;

   always #10 clk = ~clk;

   ser_status_reg dut (
      .clk(clk), .rst_n(rst_n), .reg_rd_i(reg_rd), .reg_wr_i(reg_wr),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .txbuf_wr_i(txbuf_wr),
      .rxbuf_rd_i(rxbuf_rd), .shift_load_i(shift_load), .last_bit_i(last_bit),
      .rx_done_i(rx_done), .tx_en_i(tx_en), .four_wire_i(four_wire),
      .master_i(master), .cs_n_i(cs_n), .xfer_start_i(xstart),
      .xfer_busy_i(xbusy), .xfer_inhibit_o(inhibit)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // read as software does: sample, then let the edge arm markers
   task automatic sw_read(input string tag, input logic [7:0] exp);
      reg_rd = 1; #1;
      chk(tag, rdata, exp);
      tick(); reg_rd = 0;
   endtask

   task automatic sw_write(input logic [7:0] d);
      reg_wr = 1; wdata = d; tick(); reg_wr = 0; wdata = '0;
   endtask

   task automatic t_reset();
      chk("R1 reset value", rdata, 8'h00);
      chk("R1 reset inhibit", {7'd0, inhibit}, 8'h00);
      sw_write(8'hFF);
      chk("R2 write ones", rdata, 8'h00);
   endtask

   task automatic t_rx();
      rx_done = 1; tick(); rx_done = 0;
      sw_read("R4 rx done sets", 8'h20);
      rxbuf_rd = 1; tick(); rxbuf_rd = 0;
      chk("R4 rx read clears", rdata, 8'h00);
      rx_done = 1; tick(); tick(); rx_done = 0;
      chk("R5 overrun", rdata, 8'h24);
      chk("R5 inhibit on", {7'd0, inhibit}, 8'h01);
      sw_write(8'h00);
      chk("R2 no clear without read", rdata, 8'h24);
      sw_read("R5 read before clear", 8'h24);
      sw_write(8'hFB);
      chk("R2 clear overrun only", rdata, 8'h20);
      chk("R5 inhibit off", {7'd0, inhibit}, 8'h00);
      sw_write(8'h00);
      chk("R2 marker used up", rdata, 8'h20);
      sw_read("R2 re-read", 8'h20);
      sw_write(8'h00);
      chk("R2 handshake clear", rdata, 8'h00);
   endtask

   task automatic t_tx();
      tx_en = 1; tick();
      chk("R6 enable rise", rdata, 8'h80);
      txbuf_wr = 1; tick(); txbuf_wr = 0;
      chk("R7 tx write clears", rdata, 8'h00);
      last_bit = 1; tick(); last_bit = 0;
      chk("R8 no end while full", rdata, 8'h00);
      shift_load = 1; tick(); shift_load = 0;
      chk("R6 load sets empty", rdata, 8'h80);
      last_bit = 1; tick(); last_bit = 0;
      chk("R8 end set", rdata, 8'hC0);
      txbuf_wr = 1; tick(); txbuf_wr = 0;
      chk("R7 clears both", rdata, 8'h00);
      tick();
      chk("R6 held enable no set", rdata, 8'h00);
      tx_en = 0; tick(); tx_en = 1; tick();
      chk("R6 second rise", rdata, 8'h80);
      tx_en = 0; txbuf_wr = 1; tick(); txbuf_wr = 0;
      chk("R7 cleanup", rdata, 8'h00);
   endtask

   task automatic t_conflict();
      four_wire = 1; master = 1; cs_n = 0; xstart = 1; tick(); xstart = 0;
      chk("R9 master conflict", rdata, 8'h01);
      sw_read("R9 read", 8'h01);
      sw_write(8'h00);
      chk("R2 clear conflict", rdata, 8'h00);
      four_wire = 0; xstart = 1; tick(); xstart = 0;
      chk("R9 not four-wire", rdata, 8'h00);
      four_wire = 1; master = 0; xbusy = 1; cs_n = 0; tick();
      cs_n = 1; tick();
      chk("R10 slave cs rise busy", rdata, 8'h01);
      sw_read("R10 read", 8'h01);
      sw_write(8'h00);
      xbusy = 0; cs_n = 0; tick(); cs_n = 1; tick();
      chk("R10 idle cs rise", rdata, 8'h00);
      four_wire = 0;
   endtask

   task automatic t_priority();
      shift_load = 1; tick(); shift_load = 0;
      sw_read("R11 setup", 8'h80);
      shift_load = 1; reg_wr = 1; wdata = 8'h00; tick();
      shift_load = 0; reg_wr = 0;
      chk("R11 set beats sw clear", rdata, 8'h80);
      rx_done = 1; rxbuf_rd = 1; tick();
      chk("R11 set beats hw clear", rdata, 8'hA0);
      tick(); rx_done = 0; rxbuf_rd = 0;
      chk("R5 read same cycle no overrun", rdata, 8'hA0);
      txbuf_wr = 1; rxbuf_rd = 1; tick(); txbuf_wr = 0; rxbuf_rd = 0;
      chk("R12 cleanup", rdata, 8'h00);
   endtask

   task automatic t_layout();
      shift_load = 1; tick(); shift_load = 0;
      last_bit = 1; tick(); last_bit = 0;
      rx_done = 1; tick(); tick(); rx_done = 0;
      four_wire = 1; master = 1; cs_n = 0; xstart = 1; tick(); xstart = 0;
      four_wire = 0; cs_n = 1;
      sw_read("R12 all flags layout", 8'hE5);
      sw_write(8'h1A);
      chk("R3 reserved ignored", rdata, 8'h00);
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1; tick();
      t_reset();
      t_rx();
      t_tx();
      t_conflict();
      t_priority();
      t_layout();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule